// File: doc/BRIEF.md
# Real-Time Clock Status Flags and Interrupt Unit

This block holds the event flags of a real-time clock and turns them into one interrupt line. It watches the current hour and minute counts against two programmable alarm registers. It also receives single-cycle strobes from the surrounding clock logic for these events: a chronograph count, a second, a minute, an hour, a day and two timebase periods. Each event sets a sticky flag in an eight-bit status register that software can read but cannot write.

Software acknowledges a flag in two steps. First it reads the status register while that flag is set. Then it reads the data register paired with that flag. A write never clears a flag. Each flag has an enable bit. The interrupt line is a registered OR of every flag that is both set and enabled. The calendar counters, the prescaler and the chronograph counter are outside this block: they appear only as the strobes and counts it receives.

Top module: `rtc_status_irq`

## Requirements
- R1: The status register reads at address 0 with this bit layout: bit 7 alarm, bit 6 chronograph, bit 5 day, bit 4 hour, bit 3 minute, bit 2 second, bit 1 timebase 1, bit 0 timebase 2. All flags, enables, alarm registers and the interrupt reset to 0.
- R2: The alarm flag sets in the cycle after the hour and minute counts first become equal to the alarm hour and alarm minute registers. A match that lasts does not set it again; the counts must leave the match and return to it.
- R3: A strobe on a tick input sets its flag (chronograph to bit 6, day 5, hour 4, minute 3, second 2, timebase 1 to bit 1, timebase 2 to bit 0) at the next clock edge, and the flag stays set.
- R4: The status register is read-only. A write to address 0 changes no flag.
- R5: Reading the status register arms every flag that reads as 1. A later read of a flag's paired address clears that flag if it is armed. The paired addresses are: alarm hour 2 for the alarm flag, 4 for chronograph, 5 for day, 6 for hour, 7 for minute, 8 for second, 9 for timebase 1 and 10 for timebase 2.
- R6: A read of a paired address clears nothing unless its flag was armed. Any read of a paired address disarms all flags.
- R7: If a set event and the clearing read of the same flag fall in the same cycle, the flag stays at 1.
- R8: The output irq is a register. In each cycle it equals the OR, over the eight bits, of flag AND enable as they stood one cycle earlier.
- R9: The enable register (address 1, bit layout the same as the status register), the alarm hour register (address 2, 5 bits) and the alarm minute register (address 3, 6 bits) are written by bus writes and read back at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hour_cnt | input | 5 | Current hour count |
| min_cnt | input | 6 | Current minute count |
| chron_tick | input | 1 | Chronograph count strobe |
| day_tick | input | 1 | Day rollover strobe |
| hour_tick | input | 1 | Hour rollover strobe |
| min_tick | input | 1 | Minute rollover strobe |
| sec_tick | input | 1 | Second strobe |
| tb1_tick | input | 1 | Timebase 1 strobe |
| tb2_tick | input | 1 | Timebase 2 strobe |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- irq follows the enabled flags with one cycle of delay.
- Each tick strobe leaves its flag set on the next cycle.
- A flag can fall only right after a read of its paired address.
- A rise of the alarm flag always follows a cycle in which the counts matched the alarm registers.
- A write to the status register leaves the flags unchanged.

Other behaviour needs the bench's scenarios to show it:
- The arming of flags, including how one paired read disarms the others.
- That a held match sets the alarm flag only once.
- That a set event wins when it lands on the clearing read.

// File: rtl/rtc_status_irq.sv
module rtc_status_irq #(
  parameter int HOUR_W    = 5,
  parameter int MIN_W     = 6,
  parameter int ADDR_W    = 4,
  parameter int NFLAG     = 8,
  parameter logic [ADDR_W-1:0] A_STATUS = 4'd0,
  parameter logic [ADDR_W-1:0] A_ENABLE = 4'd1,
  parameter logic [ADDR_W-1:0] A_ALM_HR = 4'd2,
  parameter logic [ADDR_W-1:0] A_ALM_MN = 4'd3,
  parameter logic [ADDR_W-1:0] A_CHRON  = 4'd4,
  parameter logic [ADDR_W-1:0] A_DAY    = 4'd5,
  parameter logic [ADDR_W-1:0] A_HOUR   = 4'd6,
  parameter logic [ADDR_W-1:0] A_MIN    = 4'd7,
  parameter logic [ADDR_W-1:0] A_SEC    = 4'd8,
  parameter logic [ADDR_W-1:0] A_TB1    = 4'd9,
  parameter logic [ADDR_W-1:0] A_TB2    = 4'd10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HOUR_W-1:0] hour_cnt,
  input  logic [MIN_W-1:0]  min_cnt,
  input  logic              chron_tick,
  input  logic              day_tick,
  input  logic              hour_tick,
  input  logic              min_tick,
  input  logic              sec_tick,
  input  logic              tb1_tick,
  input  logic              tb2_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] PAIR_ADDR [NFLAG] = '{
    A_TB2, A_TB1, A_SEC, A_MIN, A_HOUR, A_DAY, A_CHRON, A_ALM_HR
  };

  logic [NFLAG-1:0]  flags_q, armed_q, en_q, set_ev, pair_hit, clr;
  logic [HOUR_W-1:0] alm_hr_q;
  logic [MIN_W-1:0]  alm_mn_q;
  logic              match, match_q;

  assign match  = (hour_cnt == alm_hr_q) && (min_cnt == alm_mn_q);
  assign set_ev = {match & ~match_q, chron_tick, day_tick, hour_tick,
                   min_tick, sec_tick, tb1_tick, tb2_tick};

  for (genvar i = 0; i < NFLAG; i++) begin : g_pair
    assign pair_hit[i] = bus_rd && (bus_addr == PAIR_ADDR[i]);
  end

  assign clr = pair_hit & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      armed_q <= '0;
      match_q <= 1'b0;
      irq     <= 1'b0;
    end else begin
      flags_q <= set_ev | (flags_q & ~clr);
      match_q <= match;
      irq     <= |(flags_q & en_q);
      if (bus_rd && bus_addr == A_STATUS)
        armed_q <= flags_q;
      else if (|pair_hit)
        armed_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      alm_hr_q <= '0;
      alm_mn_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_ENABLE) en_q     <= bus_wdata[NFLAG-1:0];
      if (bus_addr == A_ALM_HR) alm_hr_q <= bus_wdata[HOUR_W-1:0];
      if (bus_addr == A_ALM_MN) alm_mn_q <= bus_wdata[MIN_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STATUS)      bus_rdata = flags_q;
    else if (bus_addr == A_ENABLE) bus_rdata = en_q;
    else if (bus_addr == A_ALM_HR) bus_rdata[HOUR_W-1:0] = alm_hr_q;
    else if (bus_addr == A_ALM_MN) bus_rdata[MIN_W-1:0]  = alm_mn_q;
  end

endmodule

// File: rtl/rtc_status_irq_chk.sv
module rtc_status_irq_chk #(
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] A_STATUS = 4'd0,
  parameter logic [ADDR_W-1:0] A_ALM_HR = 4'd2,
  parameter logic [ADDR_W-1:0] A_CHRON  = 4'd4,
  parameter logic [ADDR_W-1:0] A_SEC    = 4'd8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HOUR_W-1:0] hour_cnt,
  input logic [MIN_W-1:0]  min_cnt,
  input logic [HOUR_W-1:0] alm_hr,
  input logic [MIN_W-1:0]  alm_mn,
  input logic [6:0]        ticks,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        flags,
  input logic [7:0]        en,
  input logic              irq
);

  AST_IRQ_FOLLOWS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == |($past(flags & en))); // R8

  AST_CHRON_TICK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ticks[6] |=> flags[6]); // R3

  AST_SEC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ticks[2] |=> flags[2]); // R7

  AST_CHRON_FALL_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[6]) |-> $past(bus_rd && bus_addr == A_CHRON)); // R5

  AST_SEC_FALL_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(bus_rd && bus_addr == A_SEC)); // R6

  AST_ALARM_FALL_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[7]) |-> $past(bus_rd && bus_addr == A_ALM_HR)); // R5

  AST_ALARM_RISE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[7]) |-> $past(hour_cnt == alm_hr && min_cnt == alm_mn)); // R2

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr == A_STATUS && ticks == '0)
      |=> flags[6:0] == $past(flags[6:0])); // R4

endmodule

bind rtc_status_irq rtc_status_irq_chk #(
  .HOUR_W(HOUR_W), .MIN_W(MIN_W), .ADDR_W(ADDR_W),
  .A_STATUS(A_STATUS), .A_ALM_HR(A_ALM_HR), .A_CHRON(A_CHRON), .A_SEC(A_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hour_cnt(hour_cnt), .min_cnt(min_cnt),
  .alm_hr(alm_hr_q), .alm_mn(alm_mn_q),
  .ticks({chron_tick, day_tick, hour_tick, min_tick, sec_tick, tb1_tick, tb2_tick}),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .flags(flags_q), .en(en_q), .irq(irq)
);

// File: tb/rtc_status_irq_tb.sv
module rtc_status_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] hour_cnt = 5'd5;
  logic [5:0] min_cnt = 6'd9;
  logic [6:0] ticks = '0;
  logic [3:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_run = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_flags, got;

  always #4 clk = ~clk;

  rtc_status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .hour_cnt(hour_cnt), .min_cnt(min_cnt),
    .chron_tick(ticks[6]), .day_tick(ticks[5]), .hour_tick(ticks[4]),
    .min_tick(ticks[3]), .sec_tick(ticks[2]), .tb1_tick(ticks[1]),
    .tb2_tick(ticks[0]), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {tick mask[6:0], expected status after it}
  localparam logic [14:0] VEC [8] = '{
    {7'b0000001, 8'h01}, {7'b0000010, 8'h03}, {7'b0000100, 8'h07},
    {7'b1000000, 8'h47}, {7'b0000000, 8'h47}, {7'b0100000, 8'h67},
    {7'b0011000, 8'h7F}, {7'b0000100, 8'h7F}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [6:0] m);
    ticks = m;
    @(negedge clk);
    ticks = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(output logic [7:0] d);
    bus_addr = 4'd1; bus_addr = 4'd0;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    peek(got); check("R1 reset status", got, 8'h00);
    check("R8 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    peek(got); check("R1 status after reset", got, 8'h00);
    rd(4'd1, got); check("R9 enable reset", got, 8'h00);

    // R3 table walk
    foreach (VEC[i]) begin
      pulse(VEC[i][14:8]);
      peek(got);
      check("R3 tick sets flag", got, VEC[i][7:0]);
    end
    exp_flags = 8'h7F;
    check("R8 irq masked", {7'b0, irq}, 8'h00);

    // R4 write ignored
    wr(4'd0, 8'h00);
    peek(got); check("R4 status write ignored", got, 8'h7F);

    // R5 clear each flag via pair
    for (int b = 6; b >= 0; b--) begin
      rd(4'd0, got);
      check("R5 status before clear", got, exp_flags);
      rd(4'(10 - b), got);
      exp_flags[b] = 1'b0;
      peek(got);
      check("R5 paired read clears", got, exp_flags);
    end
    wr(4'd0, 8'hFF);
    peek(got); check("R4 write ones ignored", got, 8'h00);

    // R6 not armed
    pulse(7'b0000100);
    rd(4'd8, got);
    peek(got); check("R6 unarmed read keeps flag", got, 8'h04);
    rd(4'd0, got);
    rd(4'd7, got);
    rd(4'd8, got);
    peek(got); check("R6 disarm by other pair read", got, 8'h04);
    rd(4'd0, got);
    rd(4'd8, got);
    peek(got); check("R6 rearmed read clears", got, 8'h00);
    rd(4'd0, got);
    pulse(7'b0000100);
    rd(4'd8, got);
    peek(got); check("R6 set after status read stays", got, 8'h04);

    // R7 set wins
    rd(4'd0, got);
    ticks = 7'b0000100;
    rd(4'd8, got);
    ticks = '0;
    peek(got); check("R7 set beats clear", got, 8'h04);
    rd(4'd0, got); rd(4'd8, got);
    peek(got); check("R7 cleared afterwards", got, 8'h00);

    // R9 registers
    wr(4'd2, 8'd7); wr(4'd3, 8'd30);
    rd(4'd2, got); check("R9 alarm hour readback", got, 8'd7);
    rd(4'd3, got); check("R9 alarm minute readback", got, 8'd30);

    // R2 alarm
    hour_cnt = 5'd7; min_cnt = 6'd30;
    @(negedge clk);
    peek(got); check("R2 alarm sets on match", got, 8'h80);
    rd(4'd0, got); rd(4'd2, got);
    repeat (3) @(negedge clk);
    peek(got); check("R2 held match no reset", got, 8'h00);
    min_cnt = 6'd31; @(negedge clk);
    min_cnt = 6'd30; @(negedge clk);
    peek(got); check("R2 new match sets again", got, 8'h80);
    rd(4'd0, got); rd(4'd2, got);
    min_cnt = 6'd0;

    // R8 irq
    wr(4'd1, 8'h08);
    rd(4'd1, got); check("R9 enable readback", got, 8'h08);
    pulse(7'b0000100);
    @(negedge clk);
    check("R8 disabled flag no irq", {7'b0, irq}, 8'h00);
    ticks = 7'b0001000;
    @(negedge clk);
    ticks = '0;
    check("R8 irq not yet", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R8 irq raised", {7'b0, irq}, 8'h01);
    rd(4'd0, got); rd(4'd7, got);
    check("R8 irq lags clear", {7'b0, irq}, 8'h01);
    @(negedge clk);
    check("R8 irq dropped", {7'b0, irq}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule